// File: doc/BRIEF.md
# Dual-View Integer Register File

This block is the general-purpose integer register file of a processor core that executes two instruction encodings. It holds 64 registers of 64 bits. The wide view addresses all of them with a 6-bit index. The narrow view addresses only the lowest 16 registers and treats them as 32-bit quantities. The highest register is hardwired to zero. Writes to it are dropped, and reads of it return zero.

There are two combinational read ports and one write port, which is clocked. Each port has its own view-select input, so an instruction in one encoding can read while an instruction in the other encoding writes. A narrow read returns the low word of the register with the upper word cleared. A narrow write stores the word sign-extended to 64 bits. The file does not forward a value being written to a read in the same cycle. A synchronous reset clears every register.

Top module: `dvrf_top`

## Requirements
- R1: A wide-view write (view select = 0) to register k, with k from 0 to 62, stores all 64 data bits. A wide-view read of k in any later cycle returns them unchanged.
- R2: A wide-view read of index 63 always returns zero.
- R3: A write to index 63 changes no register. Index 63 still reads zero, and registers 0 to 62 keep their contents.
- R4: A narrow-view read (view select = 1) returns the low 32 bits of the selected register in bits 31:0, and zero in bits 63:32.
- R5: A narrow-view write stores its data bits 31:0 in the low word, and copies data bit 31 into all of bits 63:32. Write-data bits 63:32 are ignored.
- R6: In the narrow view only index bits 3:0 select the register, for both reads and writes. Index bits 5:4 are ignored, so register 16 + n can never be reached through the narrow view.
- R7: A read in the same cycle as a write to the same register returns the old contents. The new value appears from the cycle after the write edge.
- R8: While reset is high at a rising clock edge, every register is cleared to zero and no write takes effect.
- R9: The two read ports are independent. Each one applies its own view and index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state updates happen on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_view | input | 1 | Write view select: 0 = wide, 1 = narrow |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write data. Only bits 31:0 are used in the narrow view |
| rd0_view | input | 1 | Read port 0 view select |
| rd0_idx | input | 6 | Read port 0 register index |
| rd0_data | output | 64 | Read port 0 data, combinational |
| rd1_view | input | 1 | Read port 1 view select |
| rd1_idx | input | 6 | Read port 1 register index |
| rd1_data | output | 64 | Read port 1 data, combinational |

## Verification
Two behaviours can fall in the same cycle: a write to a register, and a read of that same register through either port, possibly in the other view. The bench provokes this on purpose in directed steps and many more times in a random phase that draws indices from a small pool. The reads in that cycle must show the contents from before the write edge, and the new value must appear in the next cycle, shaped by the reading view. Each verdict is taken from a behavioural reference model that is updated only at the clock edge.

// File: rtl/dvrf_pkg.sv
package dvrf_pkg;
    typedef enum logic {
        VIEW_WIDE   = 1'b0,
        VIEW_NARROW = 1'b1
    } view_e;
endpackage

// File: rtl/dvrf_index_map.sv
// Turns a port index into a storage row index according to the port's view.
module dvrf_index_map
    import dvrf_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int NIDX_W = 4
) (
    input  view_e              view,
    input  logic [IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]   row
);
    always_comb begin
        unique case (view)
            VIEW_NARROW: row = IDX_W'(idx[NIDX_W-1:0]);
            default:     row = idx;
        endcase
    end
endmodule

// File: rtl/dvrf_write_shaper.sv
// Widens narrow-view write data by sign extension.
module dvrf_write_shaper
    import dvrf_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32
) (
    input  view_e             view,
    input  logic [XLEN-1:0]   din,
    output logic [XLEN-1:0]   dout
);
    localparam int EXT_W = XLEN - NARROW_W;

    always_comb begin
        unique case (view)
            VIEW_NARROW: dout = {{EXT_W{din[NARROW_W-1]}}, din[NARROW_W-1:0]};
            default:     dout = din;
        endcase
    end
endmodule

// File: rtl/dvrf_read_shaper.sv
// Applies the hardwired-zero row and the narrow-view mask to a raw row value.
module dvrf_read_shaper
    import dvrf_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32,
    parameter int IDX_W    = 6,
    parameter int ZERO_ROW = 63
) (
    input  view_e             view,
    input  logic [IDX_W-1:0]  row,
    input  logic [XLEN-1:0]   raw,
    output logic [XLEN-1:0]   dout
);
    localparam int EXT_W = XLEN - NARROW_W;

    logic is_zero_row;
    assign is_zero_row = (row == IDX_W'(ZERO_ROW));

    always_comb begin
        if (is_zero_row) begin
            dout = '0;
        end else begin
            unique case (view)
                VIEW_NARROW: dout = {{EXT_W{1'b0}}, raw[NARROW_W-1:0]};
                default:     dout = raw;
            endcase
        end
    end
endmodule

// File: rtl/dvrf_top.sv
module dvrf_top
    import dvrf_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NREG        = 64,
    parameter int NARROW_W    = 32,
    parameter int NARROW_REGS = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      wr_view,
    input  logic [$clog2(NREG)-1:0]   wr_idx,
    input  logic [XLEN-1:0]           wr_data,
    input  logic                      rd0_view,
    input  logic [$clog2(NREG)-1:0]   rd0_idx,
    output logic [XLEN-1:0]           rd0_data,
    input  logic                      rd1_view,
    input  logic [$clog2(NREG)-1:0]   rd1_idx,
    output logic [XLEN-1:0]           rd1_data
);
    localparam int IDX_W    = $clog2(NREG);
    localparam int NIDX_W   = $clog2(NARROW_REGS);
    localparam int ZERO_ROW = NREG - 1;
    localparam int NRD      = 2;

    // storage
    logic [XLEN-1:0] regs_q [NREG];

    // write path
    logic [IDX_W-1:0] wr_row;
    logic [XLEN-1:0]  wr_val;
    logic             wr_commit;

    dvrf_index_map #(.IDX_W(IDX_W), .NIDX_W(NIDX_W)) u_wr_map (
        .view (view_e'(wr_view)),
        .idx  (wr_idx),
        .row  (wr_row)
    );

    dvrf_write_shaper #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_wr_shape (
        .view (view_e'(wr_view)),
        .din  (wr_data),
        .dout (wr_val)
    );

    assign wr_commit = wr_en && (wr_row != IDX_W'(ZERO_ROW));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_commit) begin
            regs_q[wr_row] <= wr_val;
        end
    end

    // read path
    view_e            rd_view [NRD];
    logic [IDX_W-1:0] rd_idx  [NRD];
    logic [XLEN-1:0]  rd_out  [NRD];

    assign rd_view[0] = view_e'(rd0_view);
    assign rd_view[1] = view_e'(rd1_view);
    assign rd_idx[0]  = rd0_idx;
    assign rd_idx[1]  = rd1_idx;

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic [IDX_W-1:0] row;

        dvrf_index_map #(.IDX_W(IDX_W), .NIDX_W(NIDX_W)) u_map (
            .view (rd_view[g]),
            .idx  (rd_idx[g]),
            .row  (row)
        );

        dvrf_read_shaper #(
            .XLEN(XLEN), .NARROW_W(NARROW_W), .IDX_W(IDX_W), .ZERO_ROW(ZERO_ROW)
        ) u_shape (
            .view (rd_view[g]),
            .row  (row),
            .raw  (regs_q[row]),
            .dout (rd_out[g])
        );
    end

    assign rd0_data = rd_out[0];
    assign rd1_data = rd_out[1];
endmodule

// File: rtl/dvrf_checker.sv
module dvrf_checker #(
    parameter int XLEN     = 64,
    parameter int IDX_W    = 6,
    parameter int NARROW_W = 32,
    parameter int NIDX_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_view,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [XLEN-1:0]   wr_data,
    input logic              rd0_view,
    input logic [IDX_W-1:0]  rd0_idx,
    input logic [XLEN-1:0]   rd0_data,
    input logic              rd1_view,
    input logic [IDX_W-1:0]  rd1_idx,
    input logic [XLEN-1:0]   rd1_data
);
    localparam logic [IDX_W-1:0] TOP_IDX = '1;

    // R2: wide read of the top index yields zero
    assert_top_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (!rd0_view && rd0_idx == TOP_IDX) |-> (rd0_data == '0));

    // R4: narrow reads clear the upper word on both ports
    assert_narrow_upper_rd0_R4: assert property (@(posedge clk) disable iff (rst)
        rd0_view |-> (rd0_data[XLEN-1:NARROW_W] == '0));
    assert_narrow_upper_rd1_R4: assert property (@(posedge clk) disable iff (rst)
        rd1_view |-> (rd1_data[XLEN-1:NARROW_W] == '0));

    // R1: a wide write is visible in full on a wide read the next cycle
    assert_wide_write_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_view && wr_idx != TOP_IDX) |=>
        (!(!rd0_view && rd0_idx == $past(wr_idx)) || rd0_data == $past(wr_data)));

    // R5: a narrow write is seen sign-extended by a wide read the next cycle
    assert_narrow_sext_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view) |=>
        (!(!rd1_view && rd1_idx == IDX_W'($past(wr_idx[NIDX_W-1:0]))) ||
         rd1_data == {{(XLEN-NARROW_W){$past(wr_data[NARROW_W-1])}},
                      $past(wr_data[NARROW_W-1:0])}));

    // R8: after a reset edge every read returns zero
    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (rd0_data == '0 && rd1_data == '0));
endmodule

bind dvrf_top dvrf_checker #(
    .XLEN(XLEN), .IDX_W(IDX_W), .NARROW_W(NARROW_W), .NIDX_W(NIDX_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd0_view(rd0_view), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_view(rd1_view), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
);

// File: tb/dvrf_top_tb.sv
module dvrf_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_view = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        rd0_view = 1'b0;
    logic [5:0]  rd0_idx = '0;
    logic [63:0] rd0_data;
    logic        rd1_view = 1'b0;
    logic [5:0]  rd1_idx = '0;
    logic [63:0] rd1_data;

    integer checks = 0;
    integer errors = 0;
    bit     done = 1'b0;

    logic [63:0] model [64];

    always #10 clk = ~clk;  // 50 MHz

    dvrf_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd0_view(rd0_view), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
        .rd1_view(rd1_view), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
    );

    function automatic logic [63:0] expect_rd(input logic v, input logic [5:0] i);
        int r;
        if (v) begin
            r = i % 16;
            return {32'd0, model[r][31:0]};
        end
        if (i == 6'd63) return 64'd0;
        return model[i];
    endfunction

    task automatic compare(input string tag, input string port,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, port, act, exp);
        end
    endtask

    // One clock: drive inputs, compare both read ports, then model the edge.
    task automatic step(input logic r, input logic we, input logic wv,
                        input logic [5:0] wi, input logic [63:0] wd,
                        input logic v0, input logic [5:0] i0,
                        input logic v1, input logic [5:0] i1, input string tag);
        int t;
        @(negedge clk);
        rst = r; wr_en = we; wr_view = wv; wr_idx = wi; wr_data = wd;
        rd0_view = v0; rd0_idx = i0; rd1_view = v1; rd1_idx = i1;
        #1;
        compare(tag, "rd0", rd0_data, expect_rd(v0, i0));
        compare(tag, "rd1", rd1_data, expect_rd(v1, i1));
        if (r) begin
            for (int k = 0; k < 64; k++) model[k] = 64'd0;
        end else if (we) begin
            t = wv ? (wi % 16) : int'(wi);
            if (t != 63) model[t] = wv ? {{32{wd[31]}}, wd[31:0]} : wd;
        end
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 64; k += 2)
            step(1'b0, 1'b0, 1'b0, 6'd0, 64'd0, 1'b0, 6'(k), 1'b0, 6'(k + 1), tag);
    endtask

    initial begin
        for (int k = 0; k < 64; k++) model[k] = 64'hDEAD_0000_0000_0000 | 64'(k);
        // R8: reset, then every register reads zero
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 64; k++) model[k] = 64'd0;
        sweep("R8");

        // R1: wide writes to every row with distinct patterns
        for (int k = 0; k < 63; k++)
            step(1'b0, 1'b1, 1'b0, 6'(k), {32'hA5C3_0000 | 32'(k), ~32'(k * 7)},
                 1'b0, 6'd63, 1'b0, 6'd0, "R1");
        sweep("R1");

        // R2 / R3: writes to the top index change nothing
        step(1'b0, 1'b1, 1'b0, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 6'd63, 1'b0, 6'd62, "R3");
        step(1'b0, 1'b1, 1'b0, 6'd63, 64'h1234_5678_9ABC_DEF0, 1'b0, 6'd63, 1'b0, 6'd63, "R2");
        sweep("R3");

        // R4: narrow reads of rows holding nonzero upper words
        for (int k = 0; k < 16; k++)
            step(1'b0, 1'b0, 1'b0, 6'd0, 64'd0, 1'b1, 6'(k), 1'b0, 6'(k), "R4");

        // R5: narrow writes, negative and positive words, junk upper data
        step(1'b0, 1'b1, 1'b1, 6'd3, 64'h5555_5555_8000_0001, 1'b0, 6'd3, 1'b1, 6'd3, "R5");
        step(1'b0, 1'b1, 1'b1, 6'd4, 64'hFFFF_FFFF_7FFF_FFFE, 1'b0, 6'd3, 1'b1, 6'd3, "R5");
        step(1'b0, 1'b0, 1'b0, 6'd0, 64'd0, 1'b0, 6'd4, 1'b0, 6'd3, "R5");

        // R6: narrow index ignores bits 5:4 for writes and reads
        step(1'b0, 1'b1, 1'b1, 6'b11_0101, 64'h0000_0000_CAFE_F00D, 1'b0, 6'd53, 1'b0, 6'd5, "R6");
        step(1'b0, 1'b1, 1'b1, 6'b11_1111, 64'h0000_0000_0BAD_BEEF, 1'b0, 6'd5, 1'b1, 6'b10_0101, "R6");
        step(1'b0, 1'b0, 1'b0, 6'd0, 64'd0, 1'b0, 6'd15, 1'b0, 6'd63, "R6");
        step(1'b0, 1'b0, 1'b0, 6'd0, 64'd0, 1'b0, 6'd53, 1'b1, 6'b01_1111, "R6");

        // R7: same-cycle write and read of one register, both views
        step(1'b0, 1'b1, 1'b0, 6'd9, 64'h0123_4567_89AB_CDEF, 1'b0, 6'd9, 1'b1, 6'd9, "R7");
        step(1'b0, 1'b1, 1'b1, 6'd9, 64'h0000_0000_F000_000F, 1'b0, 6'd9, 1'b1, 6'd9, "R7");
        step(1'b0, 1'b0, 1'b0, 6'd0, 64'd0, 1'b0, 6'd9, 1'b1, 6'd9, "R7");

        // R9: random mix; small index pool provokes collisions
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] pool [8];
            pool = '{6'd0, 6'd1, 6'd2, 6'd15, 6'd17, 6'd33, 6'd62, 6'd63};
            step(($urandom % 97) == 0, 1'($urandom), 1'($urandom),
                 pool[$urandom % 8], {$urandom, $urandom},
                 1'($urandom), pool[$urandom % 8],
                 1'($urandom), 6'($urandom), "R9");
        end

        // R8: reset mid-run clears everything
        step(1'b1, 1'b1, 1'b0, 6'd1, 64'h1, 1'b0, 6'd1, 1'b0, 6'd2, "R8");
        sweep("R8");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule